// File: doc/BRIEF.md
# PCI Slot Hotplug Register Controller

This block keeps the hotplug state of the slots on one PCI bus and presents it to firmware through four 32-bit I/O registers. Each slot has three event strobes: a coldplug insert for devices found at power-up, a hotplug insert, and a hotplug remove request. A static mask marks the slots whose devices cannot be hot-removed. A hotplug insert or remove raises the hotplug bit in a general-purpose event status byte, which interrupt logic outside the block uses to notify firmware. Firmware then reads the registers and acknowledges the bit.

Firmware finishes a removal by writing the eject register. The block picks the lowest set slot in the written value and clears that slot's pending-removal bit. If the slot is hot-pluggable, the block also clears the slot's presence bit and emits a one-cycle eject strobe that tells the slot logic to tear the device down. A platform reset request first completes every pending removal, one slot per cycle with the lowest slot first. It then reloads the presence mask from the attached-device inputs.

Register offsets use address bits [3:2]:

| Offset | Register | Read | Write |
|---|---|---|---|
| 0x0 | up | slots present and hot-pluggable | no effect |
| 0x4 | down | pending-removal mask | no effect |
| 0x8 | eject | always zero | ejects the lowest set slot |
| 0xC | removable | hot-pluggable mask | no effect |

Top module: `pci_hotplug_regs`

## Requirements
- R1: After rst_n, presence, pending removals, the event status byte, the eject strobes, the read data and `drain_busy` are all zero.
- R2: A read at offset 0x0 (address bits [3:2] = 0) returns, on `io_rdata` in the cycle after the read strobe, the presence mask ANDed with the inverse of `no_hotplug`.
- R3: A read at offset 0x4 returns the pending-removal mask. A read at offset 0x8 always returns zero.
- R4: A read at offset 0xC returns the inverse of `no_hotplug`, which is all ones except a zero for each slot that is not hot-pluggable.
- R5: A hotplug insert sets the slot's presence bit and sets bit 1 of `gpe_sts0`. A coldplug insert sets only the presence bit and leaves `gpe_sts0` unchanged.
- R6: A hotplug remove sets the slot's pending-removal bit and sets bit 1 of `gpe_sts0`.
- R7: A write at offset 0x8 selects the lowest set bit of `io_wdata` as the slot and clears its pending-removal bit. If the slot is hot-pluggable, the write also clears its presence bit and drives that slot's bit of `eject` high for exactly the next cycle. If the slot is not hot-pluggable, no eject strobe is driven.
- R8: An eject write with value zero changes nothing and drives no eject strobe.
- R9: An insert and an eject on the same slot in the same cycle leave the slot present.
- R10: `gpe_ack` clears bit 1 of `gpe_sts0`. A hotplug event in the same cycle wins and keeps the bit set.
- R11: A `sys_rst` pulse raises `drain_busy`. The block then ejects one pending slot per cycle, lowest slot first, and strobes eject only for hot-pluggable slots. When no removals remain, it loads presence from `attached` and lowers `drain_busy`. Eject writes are ignored while `drain_busy` is high.
- R12: At most one bit of `eject` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_rst | input | 1 | Platform reset request that starts the drain |
| cold_ins | input | N | Per-slot coldplug insert strobes |
| hot_ins | input | N | Per-slot hotplug insert strobes |
| hot_rem | input | N | Per-slot hotplug remove requests |
| no_hotplug | input | N | Static mask of slots that are not hot-pluggable |
| attached | input | N | Slots with a device attached, loaded into presence at the end of a drain |
| gpe_ack | input | 1 | Clears the hotplug status bit |
| io_rd | input | 1 | Register read strobe |
| io_wr | input | 1 | Register write strobe |
| io_addr | input | 4 | Byte offset within the register window |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid one cycle after `io_rd` |
| gpe_sts0 | output | 8 | Event status byte; bit 1 is the hotplug bit |
| eject | output | N | One-cycle eject strobe per slot |
| drain_busy | output | 1 | High while a reset drain is running |

## Verification
Read data, eject strobes, event status and presence all take effect one clock edge after the strobe that causes them. The bench therefore drives its stimulus on a falling edge and samples on the next falling edge, after exactly one rising edge. A scoreboard queue holds the value expected for each issued read. A monitor pops that value on the falling edge that follows the rising edge that captured the read. During a drain, one slot is ejected on each rising edge after the edge that raises `drain_busy`. The bench checks the eject strobe on each falling edge in turn until `drain_busy` falls.

// File: rtl/pci_hotplug_regs.sv
module pci_hotplug_regs #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sys_rst,
  input  logic [N-1:0] cold_ins,
  input  logic [N-1:0] hot_ins,
  input  logic [N-1:0] hot_rem,
  input  logic [N-1:0] no_hotplug,
  input  logic [N-1:0] attached,
  input  logic         gpe_ack,
  input  logic         io_rd,
  input  logic         io_wr,
  input  logic [3:0]   io_addr,
  input  logic [31:0]  io_wdata,
  output logic [31:0]  io_rdata,
  output logic [7:0]   gpe_sts0,
  output logic [N-1:0] eject,
  output logic         drain_busy
);
  localparam logic [1:0] OFS_UP = 2'd0, OFS_DOWN = 2'd1, OFS_EJ = 2'd2, OFS_RMV = 2'd3;

  logic [N-1:0] present, pending, present_n, pending_n;
  logic         hp_sts;

  wire [N-1:0] hp_en      = ~no_hotplug;
  wire         ej_wr      = io_wr && !drain_busy && (io_addr[3:2] == OFS_EJ);
  wire [N-1:0] ej_src     = drain_busy ? pending : (ej_wr ? io_wdata[N-1:0] : '0);
  wire [N-1:0] ej_one     = ej_src & (~ej_src + 1'b1);
  wire [N-1:0] ej_live    = ej_one & hp_en;
  wire         drain_done = drain_busy && (pending == '0);

  always_comb begin
    present_n = drain_done ? attached : (present & ~ej_live);
    present_n = present_n | cold_ins | hot_ins;
    pending_n = (pending & ~ej_one) | hot_rem;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present    <= '0;
      pending    <= '0;
      hp_sts     <= 1'b0;
      eject      <= '0;
      drain_busy <= 1'b0;
      io_rdata   <= '0;
    end else begin
      present <= present_n;
      pending <= pending_n;
      eject   <= ej_live;
      hp_sts  <= (hp_sts && !gpe_ack) || (|hot_ins) || (|hot_rem);
      if (sys_rst)         drain_busy <= 1'b1;
      else if (drain_done) drain_busy <= 1'b0;
      if (io_rd) begin
        case (io_addr[3:2])
          OFS_UP:   io_rdata <= 32'(present & hp_en);
          OFS_DOWN: io_rdata <= 32'(pending);
          OFS_EJ:   io_rdata <= '0;
          default:  io_rdata <= 32'(hp_en);
        endcase
      end
    end
  end

  assign gpe_sts0 = {6'b0, hp_sts, 1'b0};
endmodule

module pci_hotplug_regs_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] hot_ins,
  input logic [N-1:0] hot_rem,
  input logic [N-1:0] no_hotplug,
  input logic         io_rd,
  input logic         io_wr,
  input logic [3:0]   io_addr,
  input logic [31:0]  io_wdata,
  input logic [31:0]  io_rdata,
  input logic [7:0]   gpe_sts0,
  input logic [N-1:0] eject,
  input logic         drain_busy
);
  // R12
  eject_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(eject));
  // R7
  eject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eject != '0) |-> $past((io_wr && io_addr[3:2] == 2'd2) || drain_busy));
  // R8
  eject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr[3:2] == 2'd2 && io_wdata == '0 && !drain_busy) |=> (eject == '0));
  // R5
  hot_ins_gpe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_ins != '0) |=> gpe_sts0[1]);
  // R6
  hot_rem_gpe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_rem != '0) |=> gpe_sts0[1]);
  // R3
  feat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr[3:2] == 2'd2) |=> (io_rdata == '0));
  // R4
  rmv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr[3:2] == 2'd3) |=> (io_rdata == 32'(~$past(no_hotplug))));
endmodule

bind pci_hotplug_regs pci_hotplug_regs_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .hot_ins(hot_ins), .hot_rem(hot_rem),
  .no_hotplug(no_hotplug), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .gpe_sts0(gpe_sts0),
  .eject(eject), .drain_busy(drain_busy)
);

// File: tb/test_pci_hotplug_regs.sv
module test_pci_hotplug_regs;
  localparam int N = 32;
  logic clk = 1'b0, rst_n = 1'b0, sys_rst = 1'b0, gpe_ack = 1'b0;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [3:0] io_addr = '0;
  logic [31:0] io_wdata = '0, io_rdata;
  logic [N-1:0] cold_ins = '0, hot_ins = '0, hot_rem = '0, eject;
  logic [N-1:0] no_hotplug = 32'h0000_0003, attached = 32'h0000_00F3;
  logic [7:0] gpe_sts0;
  logic drain_busy;

  pci_hotplug_regs #(.N(N)) i_pci_hotplug_regs (.*);

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= io_rd;
  always @(negedge clk) if (rd_seen && exp_q.size() > 0) chk(tag_q.pop_front(), io_rdata, exp_q.pop_front());

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    io_rd = 1'b1; io_addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic ev(logic [N-1:0] c, logic [N-1:0] h, logic [N-1:0] r);
    cold_ins = c; hot_ins = h; hot_rem = r;
    @(negedge clk); cold_ins = '0; hot_ins = '0; hot_rem = '0;
  endtask

  task automatic wr_ej(logic [31:0] v);
    io_wr = 1'b1; io_addr = 4'h8; io_wdata = v;
    @(negedge clk); io_wr = 1'b0;
  endtask

  initial begin
    #800000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", io_rdata, 0);
    chk("R1 eject", eject, 0);
    chk("R1 gpe", gpe_sts0, 0);
    chk("R1 busy", drain_busy, 0);
    rd(4'h0, 0, "R1 up");
    ev(32'h4, 0, 0);
    chk("R5 cold no gpe", gpe_sts0, 0);
    rd(4'h0, 32'h4, "R5 cold up");
    ev(0, 32'h20, 0);
    chk("R5 hot gpe", gpe_sts0, 8'h02);
    ev(32'h1, 0, 0);
    rd(4'h0, 32'h24, "R2 up masked");
    gpe_ack = 1'b1; @(negedge clk); gpe_ack = 1'b0;
    chk("R10 ack", gpe_sts0, 0);
    gpe_ack = 1'b1; hot_ins = 32'h80; @(negedge clk); gpe_ack = 1'b0; hot_ins = '0;
    chk("R10 event wins", gpe_sts0, 8'h02);
    gpe_ack = 1'b1; @(negedge clk); gpe_ack = 1'b0;
    rd(4'hC, 32'hFFFF_FFFC, "R4 removable");
    rd(4'h8, 0, "R3 features");
    ev(0, 0, 32'h24);
    chk("R6 gpe", gpe_sts0, 8'h02);
    rd(4'h4, 32'h24, "R6 down");
    wr_ej(0);
    chk("R8 no eject", eject, 0);
    rd(4'h4, 32'h24, "R8 down kept");
    wr_ej(32'h24);
    chk("R7 eject lowest", eject, 32'h4);
    @(negedge clk);
    chk("R7 one cycle", eject, 0);
    rd(4'h4, 32'h20, "R7 down");
    rd(4'h0, 32'hA0, "R7 up");
    ev(0, 0, 32'h1);
    wr_ej(32'h1);
    chk("R7 nonhp no eject", eject, 0);
    rd(4'h4, 32'h20, "R7 nonhp down");
    io_wr = 1'b1; io_addr = 4'h8; io_wdata = 32'h20; hot_ins = 32'h20;
    @(negedge clk); io_wr = 1'b0; hot_ins = '0;
    chk("R9 eject", eject, 32'h20);
    rd(4'h0, 32'hA0, "R9 present kept");
    ev(0, 0, 32'h49);
    sys_rst = 1'b1; @(negedge clk); sys_rst = 1'b0;
    chk("R11 busy", drain_busy, 1);
    wr_ej(32'h8);
    chk("R11 slot0 no eject", eject, 0);
    @(negedge clk);
    chk("R11 slot3", eject, 32'h8);
    @(negedge clk);
    chk("R11 slot6", eject, 32'h40);
    @(negedge clk);
    chk("R11 done eject", eject, 0);
    chk("R11 done busy", drain_busy, 0);
    rd(4'h0, 32'hF0, "R11 up rebuilt");
    rd(4'h4, 0, "R11 down empty");
    @(negedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule